// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block receives characters from an asynchronous serial line. Its clock is the serial sample clock, which runs at eight times the baud rate, and `line_i` is sampled once per clock. The line must already be synchronous to that clock. When the receiver is idle, it waits for the line to go low. From that sample on, it divides time into cells of eight clocks. Each cell is resolved by a three-sample majority vote.

A frame has these parts, in this order:
- a start bit;
- 1 to 8 data bits, least significant first;
- an optional address-flag bit;
- an optional parity bit;
- one stop bit.

Each finished character is offered on a valid/ready output stream, together with its address flag, parity-error flag and framing-error flag. A one-cycle interrupt pulse marks each character taken into the buffer.

Back-pressure rules:
- While `rx_valid_o` is high and `rx_ready_i` is low, the payload is held unchanged.
- A character that completes while the buffer is still held is discarded.
- A character that completes in the same cycle as a handshake replaces the old one.

When `rx_enable_i` is low, the frame logic keeps assembling characters in step with the line, but it hands nothing to the buffer. The configuration inputs must stay stable while a frame is being received.

Top module: `osr_rx`

## Requirements
- R1: Start detection and bit timing.
  - An idle receiver starts a frame on the first clock that samples `line_i` low.
  - Every cell, including the start cell, is eight clocks long.
  - Counting that first low sample as sample 0 of the start cell, sample s of cell c is taken at clock 8c+s after the first low sample.
- R2: A bit's value is the majority of samples 3, 4 and 5 of its cell. A single disagreeing sample among them does not change the bit.
- R3: If the start cell votes high, the frame is abandoned and the receiver hunts for a new start. Nothing is delivered.
- R4: The data length is `cfg_len_i`+1 bits, received least significant first. Data bit i appears on `rx_data_o[i]`, and the unused upper bits read 0.
- R5: When `cfg_addr_i`=1, one address-flag cell follows the last data bit, and its value is reported on `rx_addr_o`. When `cfg_addr_i`=0 the cell is absent and `rx_addr_o` is 0.
- R6: When `cfg_par_en_i`=1, one parity cell follows the data and address cells.
  - `cfg_par_odd_i`=1 selects odd parity and 0 selects even parity.
  - Parity covers the data bits, the address flag and the parity bit itself.
  - `rx_perr_o` is 1 on a mismatch. It is always 0 when parity is disabled.
- R7: A stop cell that votes low sets `rx_ferr_o` for that character.
- R8: A character is taken into the buffer on the clock that samples sample 5 of its stop cell. `rx_valid_o` is high and `rx_irq_o` pulses for exactly one cycle starting on the next cycle.
- R9: A cycle with `rx_valid_o`=1 and `rx_ready_i`=1 clears `rx_valid_o`. `rx_ready_i` has no effect while `rx_valid_o` is 0.
- R10: While `rx_enable_i`=0, a completed character is not delivered. `rx_valid_o`, the payload and `rx_irq_o` are left as they were, and the following frames still decode correctly.
- R11: A character that completes while `rx_valid_o`=1 and `rx_ready_i`=0 is dropped, and the held payload stays stable.
- R12: After reset, `rx_valid_o` and `rx_irq_o` are 0 and the receiver is hunting for a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, eight times the baud rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Serial line, idle high, synchronous to clk |
| rx_enable_i | input | 1 | Allows completed characters into the buffer |
| cfg_len_i | input | 3 | Data bits per character minus one |
| cfg_addr_i | input | 1 | Frame carries an address-flag cell |
| cfg_par_en_i | input | 1 | Frame carries a parity cell |
| cfg_par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| rx_valid_o | output | 1 | Buffered character available |
| rx_ready_i | input | 1 | Consumer takes the buffered character |
| rx_data_o | output | 8 | Received data, bit 0 first on the line |
| rx_addr_o | output | 1 | Received address flag |
| rx_perr_o | output | 1 | Parity mismatch for this character |
| rx_ferr_o | output | 1 | Stop bit sampled low for this character |
| rx_irq_o | output | 1 | One-cycle pulse per character buffered |

## Verification
The hardest situation to reach from the ports is a frame whose shape breaks the normal path. One case is a start that collapses at its vote point. The other is a stop cell driven low, which also leaves the line low when hunting resumes and so causes a spurious start. The stimulus builds every frame one sample at a time. It can therefore flip a single sample inside the vote window, cut a start pulse to four samples, or hold the stop cell low, and then check that the bogus start is discarded and the next real frame decodes. Drops are provoked by holding `rx_ready_i` low across two frames and by lowering `rx_enable_i` during a frame.

// File: rtl/osr_rx_pkg.sv
package osr_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_ADDR,
    ST_PAR,
    ST_STOP
  } rx_state_t;
endpackage

// File: rtl/osr_rx_vote.sv
module osr_rx_vote #(
  parameter int OVS = 8,
  parameter int CW  = $clog2(OVS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_i,
  input  logic [CW-1:0] cnt_i,
  output logic          vote_o
);
  localparam int V0 = OVS / 2 - 1;
  localparam int V1 = OVS / 2;

  logic s0_q, s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b1;
      s1_q <= 1'b1;
    end else begin
      if (cnt_i == CW'(V0)) s0_q <= line_i;
      if (cnt_i == CW'(V1)) s1_q <= line_i;
    end
  end

  // meaningful on the third vote sample, when line_i is that sample
  assign vote_o = (s0_q & s1_q) | (s0_q & line_i) | (s1_q & line_i);
endmodule

// File: rtl/osr_rx_frame.sv
module osr_rx_frame
  import osr_rx_pkg::*;
#(
  parameter int OVS = 8,
  parameter int DW  = 8,
  parameter int LW  = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_i,
  input  logic [LW-1:0] cfg_len_i,
  input  logic          cfg_addr_i,
  input  logic          cfg_par_en_i,
  input  logic          cfg_par_odd_i,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          addr_o,
  output logic          perr_o,
  output logic          ferr_o
);
  localparam int CW   = $clog2(OVS);
  localparam int V2   = OVS / 2 + 1;
  localparam int LAST = OVS - 1;

  rx_state_t     state_q;
  logic [CW-1:0] cnt_q;
  logic [LW-1:0] idx_q;
  logic [DW-1:0] data_q;
  logic          addr_q, pacc_q, pbit_q;
  logic          vote;
  logic          at_vote, at_end;

  osr_rx_vote #(.OVS(OVS), .CW(CW)) u_vote (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (line_i),
    .cnt_i  (cnt_q),
    .vote_o (vote)
  );

  assign at_vote = (cnt_q == CW'(V2));
  assign at_end  = (cnt_q == CW'(LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      data_q  <= '0;
      addr_q  <= 1'b0;
      pacc_q  <= 1'b0;
      pbit_q  <= 1'b0;
    end else if (state_q == ST_IDLE) begin
      cnt_q <= '0;
      if (!line_i) begin
        state_q <= ST_START;
        cnt_q   <= CW'(1);
        idx_q   <= '0;
        data_q  <= '0;
        addr_q  <= 1'b0;
        pacc_q  <= 1'b0;
        pbit_q  <= 1'b0;
      end
    end else begin
      cnt_q <= at_end ? '0 : cnt_q + CW'(1);
      if (at_vote) begin
        case (state_q)
          ST_START: if (vote) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end
          ST_DATA: begin
            data_q[idx_q] <= vote;
            pacc_q        <= pacc_q ^ vote;
          end
          ST_ADDR: begin
            addr_q <= vote;
            pacc_q <= pacc_q ^ vote;
          end
          ST_PAR:  pbit_q <= vote;
          ST_STOP: begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end
          default: ;
        endcase
      end
      if (at_end) begin
        case (state_q)
          ST_START: state_q <= ST_DATA;
          ST_DATA:
            if (idx_q == cfg_len_i)
              state_q <= cfg_addr_i ? ST_ADDR : (cfg_par_en_i ? ST_PAR : ST_STOP);
            else
              idx_q <= idx_q + LW'(1);
          ST_ADDR: state_q <= cfg_par_en_i ? ST_PAR : ST_STOP;
          ST_PAR:  state_q <= ST_STOP;
          default: ;
        endcase
      end
    end
  end

  assign done_o = (state_q == ST_STOP) && at_vote;
  assign data_o = data_q;
  assign addr_o = addr_q;
  assign perr_o = cfg_par_en_i & (pacc_q ^ pbit_q ^ cfg_par_odd_i);
  assign ferr_o = ~vote;

  // R1: an idle receiver holds its cell counter at zero
  a_r1_idle_cnt_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (cnt_q == '0));

  // R8: completion is a single-cycle event
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/osr_rx_buf.sv
module osr_rx_buf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          done_i,
  input  logic [DW-1:0] data_i,
  input  logic          addr_i,
  input  logic          perr_i,
  input  logic          ferr_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic          addr_o,
  output logic          perr_o,
  output logic          ferr_o,
  output logic          irq_o
);
  logic valid_q, irq_q, load;

  assign load = done_i && en_i && (!valid_q || ready_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      irq_q   <= 1'b0;
      data_o  <= '0;
      addr_o  <= 1'b0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      irq_q <= load;
      if (load) begin
        valid_q <= 1'b1;
        data_o  <= data_i;
        addr_o  <= addr_i;
        perr_o  <= perr_i;
        ferr_o  <= ferr_i;
      end else if (valid_q && ready_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign valid_o = valid_q;
  assign irq_o   = irq_q;

  // R11: a held character keeps its payload until taken
  a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready_i) |=> (valid_q && $stable(data_o) && $stable(addr_o)
                                && $stable(perr_o) && $stable(ferr_o)));

  // R8: every interrupt pulse accompanies a buffered character
  a_r8_irq_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> valid_q);

  // R10: a completion while disabled changes nothing
  a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !en_i && !(valid_q && ready_i)) |=> ($stable(valid_q) && !irq_q));
endmodule

// File: rtl/osr_rx.sv
module osr_rx #(
  parameter int OVS = 8,
  parameter int DW  = 8,
  parameter int LW  = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_i,
  input  logic          rx_enable_i,
  input  logic [LW-1:0] cfg_len_i,
  input  logic          cfg_addr_i,
  input  logic          cfg_par_en_i,
  input  logic          cfg_par_odd_i,
  output logic          rx_valid_o,
  input  logic          rx_ready_i,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_addr_o,
  output logic          rx_perr_o,
  output logic          rx_ferr_o,
  output logic          rx_irq_o
);
  logic          done;
  logic [DW-1:0] f_data;
  logic          f_addr, f_perr, f_ferr;

  osr_rx_frame #(.OVS(OVS), .DW(DW), .LW(LW)) u_frame (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_i        (line_i),
    .cfg_len_i     (cfg_len_i),
    .cfg_addr_i    (cfg_addr_i),
    .cfg_par_en_i  (cfg_par_en_i),
    .cfg_par_odd_i (cfg_par_odd_i),
    .done_o        (done),
    .data_o        (f_data),
    .addr_o        (f_addr),
    .perr_o        (f_perr),
    .ferr_o        (f_ferr)
  );

  osr_rx_buf #(.DW(DW)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (rx_enable_i),
    .done_i  (done),
    .data_i  (f_data),
    .addr_i  (f_addr),
    .perr_i  (f_perr),
    .ferr_i  (f_ferr),
    .ready_i (rx_ready_i),
    .valid_o (rx_valid_o),
    .data_o  (rx_data_o),
    .addr_o  (rx_addr_o),
    .perr_o  (rx_perr_o),
    .ferr_o  (rx_ferr_o),
    .irq_o   (rx_irq_o)
  );
endmodule

// File: tb/test_osr_rx.sv
module test_osr_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line = 1'b1;
  logic       en = 1'b1;
  logic [2:0] cfg_len = 3'd7;
  logic       cfg_addr = 1'b0, cfg_par = 1'b0, cfg_odd = 1'b0;
  logic       ready = 1'b0;
  logic       valid, addr, perr, ferr, irq;
  logic [7:0] data;

  int checks = 0, fails = 0, cyc = 0, due = -1;
  bit chk_on = 1'b0;
  string ph = "R1";
  logic [7:0] d_data; logic d_addr, d_perr, d_ferr;
  logic [7:0] m_data = 0; logic m_addr = 0, m_perr = 0, m_ferr = 0, m_valid = 0, m_irq = 0;

  always #5 clk = ~clk;

  osr_rx i_osr_rx (
    .clk(clk), .rst_n(rst_n), .line_i(line), .rx_enable_i(en),
    .cfg_len_i(cfg_len), .cfg_addr_i(cfg_addr), .cfg_par_en_i(cfg_par),
    .cfg_par_odd_i(cfg_odd), .rx_valid_o(valid), .rx_ready_i(ready),
    .rx_data_o(data), .rx_addr_o(addr), .rx_perr_o(perr), .rx_ferr_o(ferr),
    .rx_irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (%s) t=%0t actual=%0h expected=%0h", tag, ph, $time, act, exp);
    end
  endtask

  // behavioural reference: one buffered slot, arrivals at scheduled cycles
  always @(posedge clk) begin
    cyc++;
    if (cyc == due && en && (!m_valid || ready)) begin
      m_valid = 1; m_irq = 1;
      m_data = d_data; m_addr = d_addr; m_perr = d_perr; m_ferr = d_ferr;
    end else begin
      m_irq = 0;
      if (m_valid && ready) m_valid = 0;
    end
  end

  always @(negedge clk) if (chk_on) begin
    chk(valid == m_valid, "R9 valid", valid, m_valid);
    chk(irq == m_irq, "R8 irq", irq, m_irq);
    if (m_valid) begin
      chk(data == m_data, "R4 data", data, m_data);
      chk(addr == m_addr, "R5 addr", addr, m_addr);
      chk(perr == m_perr, "R6 perr", perr, m_perr);
      chk(ferr == m_ferr, "R7 ferr", ferr, m_ferr);
    end
  end

  task automatic send(input logic [7:0] d, input logic a, input bit badpar,
                      input logic stopv, input bit noise);
    int n = int'(cfg_len) + 1;
    int k;
    logic [7:0] dm;
    logic p, b;
    dm = d & 8'((1 << n) - 1);
    p  = (^dm) ^ (cfg_addr & a) ^ cfg_odd ^ badpar;
    k  = 1 + n + int'(cfg_addr) + int'(cfg_par);
    @(negedge clk);
    d_data = dm; d_addr = cfg_addr & a; d_perr = cfg_par & badpar; d_ferr = ~stopv;
    due = cyc + 1 + 8 * k + 5;
    for (int c = 0; c <= k; c++) begin
      if (c == 0) b = 1'b0;
      else if (c <= n) b = dm[c-1];
      else if (c == k) b = stopv;
      else if (cfg_addr && c == n + 1) b = a;
      else b = p;
      for (int j = 0; j < 8; j++) begin
        if (!(c == 0 && j == 0)) @(negedge clk);
        line = (noise && c >= 1 && c <= n && j == 4) ? ~b : b;
      end
    end
    repeat (12) @(negedge clk) line = 1'b1;
  endtask

  task automatic rd();
    @(negedge clk) ready = 1'b1;
    @(negedge clk) ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(valid == 1'b0, "R12 valid after reset", valid, 0);
    chk(irq == 1'b0, "R12 irq after reset", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid == 1'b0 && irq == 1'b0, "R12 idle", valid, 0);
    chk_on = 1'b1;

    ph = "R1";  send(8'hA5, 0, 0, 1, 0); rd();
    ph = "R4";  send(8'h3C, 0, 0, 1, 0); rd();
    cfg_len = 3'd5; send(8'hFF, 0, 0, 1, 0); rd();
    cfg_len = 3'd0; send(8'h01, 0, 0, 1, 0); rd();
    ph = "R5";  cfg_len = 3'd5; cfg_addr = 1;
    send(8'h2A, 1, 0, 1, 0); rd();
    send(8'h15, 0, 0, 1, 0); rd();
    ph = "R6";  cfg_par = 1; cfg_odd = 0;
    send(8'h33, 1, 0, 1, 0); rd();
    send(8'h33, 1, 1, 1, 0); rd();
    cfg_odd = 1; cfg_addr = 0; cfg_len = 3'd7;
    send(8'h81, 0, 0, 1, 0); rd();
    send(8'h80, 0, 1, 1, 0); rd();
    ph = "R7";  send(8'h5A, 0, 0, 0, 0); rd();
    send(8'h5B, 0, 0, 1, 0); rd();
    ph = "R2";  send(8'hC3, 0, 0, 1, 1); rd();
    cfg_par = 0; send(8'h0F, 0, 0, 1, 1); rd();
    ph = "R3";
    @(negedge clk);
    for (int j = 0; j < 4; j++) begin line = 1'b0; @(negedge clk); end
    line = 1'b1;
    repeat (16) @(negedge clk);
    chk(valid == 1'b0, "R3 glitch delivered nothing", valid, 0);
    send(8'h96, 0, 0, 1, 0); rd();
    ph = "R10"; en = 1'b0;
    send(8'h77, 0, 0, 1, 0);
    chk(valid == 1'b0, "R10 disabled buffer empty", valid, 0);
    en = 1'b1;
    send(8'h78, 0, 0, 1, 0); rd();
    ph = "R11";
    send(8'h11, 0, 0, 1, 0);
    send(8'h22, 0, 0, 1, 0);
    chk(data == 8'h11, "R11 held payload kept", data, 8'h11);
    rd();
    repeat (4) @(negedge clk);
    chk(valid == 1'b0, "R9 cleared by handshake", valid, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule